// File: doc/BRIEF.md
# Skewed Precharge/Evaluate Strobe Sequencer

This block drives the control strobes for a chain of dynamic logic stages. Every stage moves through a fixed cycle of phases: precharge (its output node is pulled to logic 1), evaluate, and then one or two hold phases. In the hold phases the stage keeps its result, and that result is the input of the next stage. Each stage runs exactly one phase behind the stage before it. As a result, the evaluate phase of a stage always falls on the precharge phase of the stage that follows it.

A mode input selects one of two schemes. The 3-phase scheme uses precharge, evaluate and hold. The 4-phase scheme inserts a second hold phase. With that phase, a stage cannot precharge again until the stage two positions downstream has finished evaluating, so a precharge cannot disturb a value that is still being consumed. The length of a phase, in clock cycles, comes from an input. Mode and phase length are captured only at the start of a full sequence. When enable is low, or during reset, every stage is held in precharge.

Top module: `dyn_stage_sequencer`

## Requirements
- R1: While `rst` is high (synchronous, active high) the outputs read as follows after the clock edge: every `pre_o` bit is 1, every `eva_o` bit is 0, and `phase_idx` is 0.
- R2: One clock edge after `en` is sampled low, the block shows the idle pattern: all `pre_o` bits are 1, all `eva_o` bits are 0, and `phase_idx` is 0. The idle pattern remains while `en` stays low.
- R3: The first edge with `en` high after idle or reset starts a sequence at global phase 0. Each global phase lasts L clock cycles, where L is the captured `phase_len`. A `phase_len` of 0 is treated as 1.
- R4: `phase_idx` steps 0,1,...,P-1 and then back to 0, where P=3 when the captured mode is 0 and P=4 when the captured mode is 1 (`mode_4ph`). The value 3 never appears in 3-phase mode.
- R5: Stage k has local phase (phase_idx - k) mod P. Local phase 0 (precharge) drives pre=1, eva=0. Local phase 1 (evaluate) drives pre=0, eva=1. Local phases 2 and 3 (hold) drive both strobes to 0.
- R6: No stage ever has `pre_o` and `eva_o` high at the same time.
- R7: Two neighbouring stages never have `eva_o` high together.
- R8: In 4-phase mode, whenever stage k+2 evaluates, stage k has both strobes low (second hold).
- R9: Whenever stage k evaluates, stage k+1 is in precharge.
- R10: Stage k and stage k+P always show identical strobes.
- R11: `mode_4ph` and `phase_len` are captured only at the start of a sequence (on enable start, or on the wrap from phase P-1 to 0). A change in the middle of a sequence takes effect at the first edge of the next sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces all stages to precharge |
| mode_4ph | input | 1 | 0 = 3-phase scheme, 1 = 4-phase scheme with second hold |
| phase_len | input | LEN_W | Clock cycles per phase (0 counts as 1) |
| pre_o | output | NUM_STAGES | Precharge strobe per stage |
| eva_o | output | NUM_STAGES | Evaluate strobe per stage |
| phase_idx | output | 2 | Current global phase |

## Verification
The bench builds the block with NUM_STAGES=9 and LEN_W=4. Nine stages give more than two full repeats of both the three-stage and the four-stage strobe pattern, so the periodicity rule and the two-stage lookahead of the second hold are both exercised at several positions in the chain. A 4-bit length covers phase lengths of 0, 1 and several cycles, which reaches the single-cycle phase corner and the zero-length rule. The directed runs change mode and length in the middle of a sequence and toggle enable while a sequence is running.

// File: rtl/dss_pkg.sv
package dss_pkg;
  // Local phase of one stage within its own cycle
  typedef enum logic [1:0] {
    PH_PRE   = 2'd0,
    PH_EVA   = 2'd1,
    PH_HOLDA = 2'd2,
    PH_HOLDB = 2'd3
  } stage_ph_t;

  localparam int GPH_W = 2;
endpackage

// File: rtl/dss_phase_timer.sv
// Counts cycles inside a phase and holds the captured sequence configuration.
module dss_phase_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             mode_in,
  input  logic [LEN_W-1:0] len_in,
  input  logic             last_ph,
  output logic             start,
  output logic             tick,
  output logic             mode_q,
  output logic             mode_nx
);
  logic             active_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_eff;
  logic             load;

  assign len_eff = (len_q == '0) ? LEN_W'(1) : len_q;
  assign start   = en & ~active_q;
  assign tick    = en & active_q & (cnt_q == len_eff - LEN_W'(1));
  assign load    = ~en | start | (tick & last_ph);
  assign mode_nx = load ? mode_in : mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      len_q    <= '0;
      mode_q   <= 1'b0;
    end else begin
      active_q <= en;
      if (~en | start | tick) cnt_q <= '0;
      else                    cnt_q <= cnt_q + LEN_W'(1);
      if (load) begin
        len_q  <= len_in;
        mode_q <= mode_in;
      end
    end
  end
endmodule

// File: rtl/dss_phase_ring.sv
// Global phase counter, 0..2 or 0..3 depending on the captured mode.
module dss_phase_ring
  import dss_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  input  logic             tick,
  input  logic             four_ph,
  output logic [GPH_W-1:0] g_q,
  output logic [GPH_W-1:0] g_nx,
  output logic             last_ph
);
  assign last_ph = (g_q == (four_ph ? GPH_W'(3) : GPH_W'(2)));

  always_comb begin
    if (~en | start)  g_nx = '0;
    else if (tick)    g_nx = last_ph ? '0 : g_q + GPH_W'(1);
    else              g_nx = g_q;
  end

  always_ff @(posedge clk) begin
    if (rst) g_q <= '0;
    else     g_q <= g_nx;
  end
endmodule

// File: rtl/dss_stage_decode.sv
// Maps the global phase onto one stage's strobes, skewed by its position.
module dss_stage_decode
  import dss_pkg::*;
#(
  parameter int STAGE = 0
) (
  input  logic [GPH_W-1:0] gph,
  input  logic             four_ph,
  output logic             pre_d,
  output logic             eva_d
);
  localparam logic [2:0] OFF3 = 3'(STAGE % 3);
  localparam logic [2:0] OFF4 = 3'(STAGE % 4);

  logic [2:0] per;
  logic [2:0] sum;
  stage_ph_t  lph;

  always_comb begin
    per = four_ph ? 3'd4 : 3'd3;
    sum = {1'b0, gph} + per - (four_ph ? OFF4 : OFF3);
    if (sum >= per) sum = sum - per;
    lph   = stage_ph_t'(sum[1:0]);
    pre_d = (lph == PH_PRE);
    eva_d = (lph == PH_EVA);
  end
endmodule

// File: rtl/dyn_stage_sequencer.sv
module dyn_stage_sequencer
  import dss_pkg::*;
#(
  parameter int NUM_STAGES = 6,
  parameter int LEN_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic                  mode_4ph,
  input  logic [LEN_W-1:0]      phase_len,
  output logic [NUM_STAGES-1:0] pre_o,
  output logic [NUM_STAGES-1:0] eva_o,
  output logic [1:0]            phase_idx
);
  logic             start, tick, last_ph;
  logic             mode_act, mode_nx;
  logic [GPH_W-1:0] g_q, g_nx;
  logic [NUM_STAGES-1:0] pre_d, eva_d;

  dss_phase_timer #(.LEN_W(LEN_W)) i_timer (
    .clk(clk), .rst(rst), .en(en), .mode_in(mode_4ph), .len_in(phase_len),
    .last_ph(last_ph), .start(start), .tick(tick),
    .mode_q(mode_act), .mode_nx(mode_nx)
  );

  dss_phase_ring i_ring (
    .clk(clk), .rst(rst), .en(en), .start(start), .tick(tick),
    .four_ph(mode_act), .g_q(g_q), .g_nx(g_nx), .last_ph(last_ph)
  );

  // Decode from next state so the registered strobes line up with phase_idx
  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    dss_stage_decode #(.STAGE(k)) i_dec (
      .gph(g_nx), .four_ph(mode_nx), .pre_d(pre_d[k]), .eva_d(eva_d[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pre_o <= '1;
      eva_o <= '0;
    end else begin
      pre_o <= pre_d;
      eva_o <= eva_d;
    end
  end

  assign phase_idx = g_q;
endmodule

// File: rtl/dss_checker.sv
module dss_checker #(
  parameter int NUM_STAGES = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  en,
  input logic                  mode_act,
  input logic [NUM_STAGES-1:0] pre_o,
  input logic [NUM_STAGES-1:0] eva_o,
  input logic [1:0]            phase_idx
);
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (&pre_o && eva_o == '0 && phase_idx == 2'd0));

  p_enable_idle_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!en) |-> (&pre_o && eva_o == '0 && phase_idx == 2'd0));

  p_phase_step_r4: assert property (@(posedge clk) disable iff (rst)
    (phase_idx != $past(phase_idx)) |->
      (phase_idx == $past(phase_idx) + 2'd1 || phase_idx == 2'd0));

  p_no_three_r4: assert property (@(posedge clk) disable iff (rst)
    !mode_act |-> phase_idx != 2'd3);

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_own
    p_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
      !(pre_o[k] && eva_o[k]));
  end

  for (genvar k = 0; k + 1 < NUM_STAGES; k++) begin : g_nb
    p_neighbour_eva_r7: assert property (@(posedge clk) disable iff (rst)
      !(eva_o[k] && eva_o[k+1]));
    p_eva_meets_pre_r9: assert property (@(posedge clk) disable iff (rst)
      eva_o[k] |-> pre_o[k+1]);
  end

  for (genvar k = 0; k + 2 < NUM_STAGES; k++) begin : g_h2
    p_second_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (mode_act && eva_o[k+2]) |-> (!pre_o[k] && !eva_o[k]));
  end

  for (genvar k = 0; k + 3 < NUM_STAGES; k++) begin : g_rep
    p_repeat3_r10: assert property (@(posedge clk) disable iff (rst)
      (!mode_act && en && $past(en)) |->
        (pre_o[k] == pre_o[k+3] && eva_o[k] == eva_o[k+3]));
  end

  for (genvar k = 0; k + 4 < NUM_STAGES; k++) begin : g_rep4
    p_repeat4_r10: assert property (@(posedge clk) disable iff (rst)
      (mode_act && en && $past(en)) |->
        (pre_o[k] == pre_o[k+4] && eva_o[k] == eva_o[k+4]));
  end
endmodule

bind dyn_stage_sequencer dss_checker #(.NUM_STAGES(NUM_STAGES)) i_chk (
  .clk(clk), .rst(rst), .en(en), .mode_act(mode_act),
  .pre_o(pre_o), .eva_o(eva_o), .phase_idx(phase_idx)
);

// File: tb/test_dyn_stage_sequencer.sv
`timescale 1ns/1ps
module test_dyn_stage_sequencer;
  localparam int NS = 9;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en  = 1'b0;
  logic          mode_4ph = 1'b0;
  logic [LW-1:0] phase_len = '0;
  logic [NS-1:0] pre_o, eva_o;
  logic [1:0]    phase_idx;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // {mode, len, cycles}
  localparam logic [12:0] VEC [7] = '{
    {1'b0, 4'd1, 8'd12}, {1'b0, 4'd3, 8'd20}, {1'b1, 4'd1, 8'd16},
    {1'b1, 4'd2, 8'd20}, {1'b1, 4'd5, 8'd45}, {1'b0, 4'd0, 8'd9},
    {1'b1, 4'd0, 8'd8}
  };

  always #2.5 clk = ~clk;

  dyn_stage_sequencer #(.NUM_STAGES(NS), .LEN_W(LW)) i_dyn_stage_sequencer (
    .clk(clk), .rst(rst), .en(en), .mode_4ph(mode_4ph), .phase_len(phase_len),
    .pre_o(pre_o), .eva_o(eva_o), .phase_idx(phase_idx)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk(req, int'(pre_o), (1 << NS) - 1);
    chk(req, int'(eva_o), 0);
    chk(req, int'(phase_idx), 0);
  endtask

  // expected strobes for global phase g with period p (R5, R6, R7, R9, R10)
  task automatic check_phase(input string req, input int g, input int p);
    int ep = 0;
    int ee = 0;
    chk({req, " phase_idx R4"}, int'(phase_idx), g);
    for (int k = 0; k < NS; k++) begin
      int lp = (g + p - (k % p)) % p;
      if (lp == 0) ep |= (1 << k);
      if (lp == 1) ee |= (1 << k);
    end
    chk({req, " pre R5"}, int'(pre_o), ep);
    chk({req, " eva R5"}, int'(eva_o), ee);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
  endtask

  initial begin
    do_reset();

    // Table walk: R3 R4 R5 from a fresh start with each configuration
    for (int v = 0; v < 7; v++) begin
      int m   = int'(VEC[v][12]);
      int l   = int'(VEC[v][11:8]);
      int n   = int'(VEC[v][7:0]);
      int le  = (l == 0) ? 1 : l;
      int p   = m ? 4 : 3;
      do_reset();
      mode_4ph = m[0]; phase_len = LW'(l); rst = 1'b0; en = 1'b1;
      for (int j = 0; j < n; j++) begin
        @(negedge clk);
        check_phase("R3 table", (j / le) % p, p);
      end
    end

    // R11: change config mid-sequence, takes effect at next wrap
    do_reset();
    mode_4ph = 1'b0; phase_len = 4'd2; rst = 1'b0; en = 1'b1;
    for (int j = 0; j < 18; j++) begin
      @(negedge clk);
      if (j < 6) check_phase("R11 old cfg", (j / 2) % 3, 3);
      else       check_phase("R11 new cfg", (j - 6) % 4, 4);
      if (j == 1) begin mode_4ph = 1'b1; phase_len = 4'd1; end
    end

    // R2: enable low mid-run forces idle, restart uses current inputs
    do_reset();
    mode_4ph = 1'b1; phase_len = 4'd3; rst = 1'b0; en = 1'b1;
    repeat (7) @(negedge clk);
    en = 1'b0;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      check_idle("R2 enable low");
      mode_4ph = 1'b0; phase_len = 4'd2;
    end
    en = 1'b1;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      check_phase("R2 restart R3", (j / 2) % 3, 3);
    end

    // R1: reset asserted while running
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_idle("R1 reset while running");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule